// File: doc/BRIEF.md
# Flash command and protection controller

This block sits between a register interface and a 32 KB flash array of 256 pages, each 128 bytes wide and read as 32-bit words. Software writes a single command word. The word carries a key, a page number and an opcode. The block checks the word and runs one of six operations:

- programming a page
- erasing a page
- erasing the whole array
- locking a region
- unlocking a region
- raising the security bit

Program and erase operations are passed to the array through a request/done handshake. In this project the array is a stub that answers each request with a done pulse. Lock, unlock and security commands act on bits held inside the block and complete at once.

The block keeps eight region lock bits. Each bit covers 32 consecutive pages. Any program or erase that would touch a locked region is refused. The block also keeps a one-way security bit. While that bit is set, access requests from the debug port and from the external programming port are refused.

An external erase pin is synchronised and timed against a millisecond tick. A long enough hold on this pin does the following, in order:

1. It wipes all lock bits at once.
2. It runs a full-array erase.
3. It clears the security bit, and only once that erase is done.

Completion and error conditions land in status flags. Each flag has its own interrupt enable, and all flags clear on a status read.

The command port is a plain write strobe with no back-pressure. A write that arrives while the block is busy is not queued. It is dropped and flagged as a command error, so software must poll `busy` or wait for the done flag.

Top module: `flash_guard`

## Requirements
- R1: A command word has the key in bits [31:24], the page number in bits [15:8] and the opcode in bits [2:0]. If the key does not equal the `KEY` parameter (default 0xA5), the command does nothing and sets `st_cmd_err`.
- R2: Opcode 1 is page program and opcode 2 is page erase. When the target region is unlocked, the block gives a one-cycle `arr_req` with `arr_op` 0 for program or 1 for page erase, and `arr_page` set to the page. `busy` stays high until `arr_done` arrives, and then `st_done` is set.
- R3: A page program or page erase whose region (page bits [7:5]) is locked issues no `arr_req` and sets `st_lock_err`.
- R4: Opcode 4 sets, and opcode 5 clears, the lock bit `lock_q[page[7:5]]`. Either one completes at once and sets `st_done`.
- R5: Opcode 3 is full erase. It is refused with `st_lock_err` when any lock bit is set. Otherwise it issues `arr_req` with `arr_op` 2.
- R6: Opcode 6 sets `secure`. No command clears `secure`; it falls only when the `arr_done` of an erase-pin wipe arrives.
- R7: While `secure` is high, `dbg_gnt` and `xprog_gnt` stay low. Otherwise each one follows its request.
- R8: The erase pin is accepted only after it has stayed high, after synchronising, for (`HOLD_MS`+1) × `TICK_CYCLES` cycles. A shorter pulse has no effect.
- R9: An accepted erase pin does three things. It clears all `lock_q` bits. It issues a full erase (`arr_op` 2) while `secure` is still high. It clears `secure` after that erase's `arr_done`.
- R10: While `busy` is high, a command write sets `st_cmd_err` and is not executed. Opcodes 0 and 7 also set `st_cmd_err`.
- R11: A status flag stays set until an `sts_rd` pulse clears it. `irq` is high exactly when a set flag has its enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 32 | Command word: key, page, opcode |
| sts_rd | input | 1 | Status read pulse, clears the flags |
| ie_done | input | 1 | Interrupt enable for the done flag |
| ie_lock | input | 1 | Interrupt enable for the lock-error flag |
| ie_cmd | input | 1 | Interrupt enable for the command-error flag |
| erase_pin | input | 1 | Asynchronous external erase pin |
| dbg_req | input | 1 | Debug port access request |
| xprog_req | input | 1 | External programming port access request |
| arr_done | input | 1 | Array done pulse |
| busy | output | 1 | An array operation is in flight |
| st_done | output | 1 | Command-done flag |
| st_lock_err | output | 1 | Lock-error flag |
| st_cmd_err | output | 1 | Command-error flag |
| irq | output | 1 | Interrupt |
| lock_q | output | 8 | Region lock bits |
| secure | output | 1 | Security bit |
| dbg_gnt | output | 1 | Debug access grant |
| xprog_gnt | output | 1 | External programming access grant |
| arr_req | output | 1 | One-cycle array request |
| arr_op | output | 2 | Array operation: 0 program, 1 page erase, 2 full erase |
| arr_page | output | 8 | Target page |

## Verification
A table of command words tries the block with several kinds of input:

- valid and corrupted keys, which separate key checking from opcode decoding;
- page operations on pages at both edges of a locked region and on pages in a free region, which show that the region is decoded from the top page bits;
- full erase with and without a lock set, which separates the whole-array lock check from the per-page check;
- undefined opcodes.

Directed sequences then cover three further cases:

- A second write during a busy operation, which tells rejection apart from queueing.
- Erase-pin pulses just short of the hold time and well beyond it, which locate the filter threshold. The long pulse also shows that security stays set until the wipe finishes.
- Interrupt enables with flag reads, which show that the flags stay set until read.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_PERASE = 3'd2,
    OP_FERASE = 3'd3,
    OP_SETLK  = 3'd4,
    OP_CLRLK  = 3'd5,
    OP_SETSEC = 3'd6
  } op_e;

  typedef enum logic [1:0] {
    ARR_PROG   = 2'd0,
    ARR_PERASE = 2'd1,
    ARR_FERASE = 2'd2
  } arr_e;

  typedef struct packed {
    logic done;
    logic lock_err;
    logic cmd_err;
  } evt_t;
endpackage

// File: rtl/fg_pin_filter.sv
module fg_pin_filter #(
  parameter int TICK_CYCLES = 48000,
  parameter int HOLD_MS     = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fire
);
  localparam int CW = $clog2(TICK_CYCLES + 1);
  localparam int MW = $clog2(HOLD_MS + 2);

  logic [1:0]    sync_q;
  logic [CW-1:0] psc_q;
  logic [MW-1:0] ms_q;
  logic          spent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      psc_q   <= '0;
      ms_q    <= '0;
      spent_q <= 1'b0;
      fire    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin};
      fire   <= 1'b0;
      if (!sync_q[1]) begin
        psc_q   <= '0;
        ms_q    <= '0;
        spent_q <= 1'b0;
      end else if (!spent_q) begin
        if (psc_q == CW'(TICK_CYCLES - 1)) begin
          psc_q <= '0;
          if (ms_q == MW'(HOLD_MS)) begin
            fire    <= 1'b1;
            spent_q <= 1'b1;
          end else begin
            ms_q <= ms_q + 1'b1;
          end
        end else begin
          psc_q <= psc_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fg_lock_bank.sv
module fg_lock_bank #(
  parameter int REGIONS = 8,
  localparam int RW = $clog2(REGIONS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_lk,
  input  logic               clr_lk,
  input  logic [RW-1:0]      region,
  input  logic               wipe_locks,
  input  logic               set_sec,
  input  logic               clr_sec,
  output logic [REGIONS-1:0] locks,
  output logic               secure
);
  for (genvar r = 0; r < REGIONS; r++) begin : g_lock
    logic hit;
    assign hit = (region == RW'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               locks[r] <= 1'b0;
      else if (wipe_locks)      locks[r] <= 1'b0;
      else if (set_lk && hit)   locks[r] <= 1'b1;
      else if (clr_lk && hit)   locks[r] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       secure <= 1'b0;
    else if (set_sec) secure <= 1'b1;
    else if (clr_sec) secure <= 1'b0;
  end
endmodule

// File: rtl/fg_sequencer.sv
module fg_sequencer
  import flash_guard_pkg::*;
#(
  parameter int          PAGES   = 256,
  parameter int          REGIONS = 8,
  parameter logic [7:0]  KEY     = 8'hA5,
  localparam int PW = $clog2(PAGES),
  localparam int RW = $clog2(REGIONS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [31:0]        cmd_word,
  input  logic [REGIONS-1:0] locks,
  input  logic               pin_fire,
  input  logic               arr_done,
  output logic               arr_req,
  output logic [1:0]         arr_op,
  output logic [PW-1:0]      arr_page,
  output logic               busy,
  output logic               set_lk,
  output logic               clr_lk,
  output logic               set_sec,
  output logic               clr_sec,
  output logic [RW-1:0]      region,
  output evt_t               ev
);
  typedef enum logic [1:0] {S_IDLE, S_CMD, S_WIPE} st_e;

  st_e           st_q;
  logic          pend_q;
  logic          key_ok, idle, wipe_go, take, issue;
  op_e           op;
  logic [PW-1:0] page;
  arr_e          iss_op;
  logic          unused_word;

  assign unused_word = ^cmd_word;
  assign key_ok  = (cmd_word[31:24] == KEY);
  assign op      = op_e'(cmd_word[2:0]);
  assign page    = cmd_word[8 +: PW];
  assign region  = page[PW-1 -: RW];
  assign idle    = (st_q == S_IDLE);
  assign wipe_go = idle && (pend_q || pin_fire);
  assign take    = cmd_wr && idle && !wipe_go;
  assign busy    = !idle;
  assign clr_sec = (st_q == S_WIPE) && arr_done;

  always_comb begin
    ev      = '0;
    set_lk  = 1'b0;
    clr_lk  = 1'b0;
    set_sec = 1'b0;
    issue   = 1'b0;
    iss_op  = ARR_PROG;
    if (cmd_wr && !take) begin
      ev.cmd_err = 1'b1;
    end else if (take) begin
      if (!key_ok) begin
        ev.cmd_err = 1'b1;
      end else begin
        unique case (op)
          OP_PROG, OP_PERASE: begin
            if (locks[region]) ev.lock_err = 1'b1;
            else begin
              issue  = 1'b1;
              iss_op = (op == OP_PROG) ? ARR_PROG : ARR_PERASE;
            end
          end
          OP_FERASE: begin
            if (|locks) ev.lock_err = 1'b1;
            else begin
              issue  = 1'b1;
              iss_op = ARR_FERASE;
            end
          end
          OP_SETLK:  begin set_lk  = 1'b1; ev.done = 1'b1; end
          OP_CLRLK:  begin clr_lk  = 1'b1; ev.done = 1'b1; end
          OP_SETSEC: begin set_sec = 1'b1; ev.done = 1'b1; end
          default:   ev.cmd_err = 1'b1;
        endcase
      end
    end
    if (st_q == S_CMD && arr_done) ev.done = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      pend_q   <= 1'b0;
      arr_req  <= 1'b0;
      arr_op   <= '0;
      arr_page <= '0;
    end else begin
      arr_req <= 1'b0;
      if (wipe_go) begin
        st_q     <= S_WIPE;
        pend_q   <= 1'b0;
        arr_req  <= 1'b1;
        arr_op   <= ARR_FERASE;
        arr_page <= '0;
      end else begin
        if (pin_fire) pend_q <= 1'b1;
        if (issue) begin
          st_q     <= S_CMD;
          arr_req  <= 1'b1;
          arr_op   <= iss_op;
          arr_page <= page;
        end else if (!idle && arr_done) begin
          st_q <= S_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/fg_status.sv
module fg_status
  import flash_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  evt_t ev,
  input  logic sts_rd,
  input  logic ie_done,
  input  logic ie_lock,
  input  logic ie_cmd,
  output evt_t flags,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (sts_rd ? '0 : flags) | ev;
  end

  assign irq = (flags.done & ie_done) | (flags.lock_err & ie_lock) |
               (flags.cmd_err & ie_cmd);
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int         PAGES       = 256,
  parameter int         REGIONS     = 8,
  parameter logic [7:0] KEY         = 8'hA5,
  parameter int         TICK_CYCLES = 48000,
  parameter int         HOLD_MS     = 50,
  localparam int PW = $clog2(PAGES),
  localparam int RW = $clog2(REGIONS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [31:0]        cmd_word,
  input  logic               sts_rd,
  input  logic               ie_done,
  input  logic               ie_lock,
  input  logic               ie_cmd,
  input  logic               erase_pin,
  input  logic               dbg_req,
  input  logic               xprog_req,
  input  logic               arr_done,
  output logic               busy,
  output logic               st_done,
  output logic               st_lock_err,
  output logic               st_cmd_err,
  output logic               irq,
  output logic [REGIONS-1:0] lock_q,
  output logic               secure,
  output logic               dbg_gnt,
  output logic               xprog_gnt,
  output logic               arr_req,
  output logic [1:0]         arr_op,
  output logic [PW-1:0]      arr_page
);
  logic          pin_fire, set_lk, clr_lk, set_sec, clr_sec;
  logic [RW-1:0] region;
  evt_t          ev, flags;

  fg_pin_filter #(.TICK_CYCLES(TICK_CYCLES), .HOLD_MS(HOLD_MS)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin(erase_pin), .fire(pin_fire)
  );

  fg_sequencer #(.PAGES(PAGES), .REGIONS(REGIONS), .KEY(KEY)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .locks(lock_q), .pin_fire(pin_fire), .arr_done(arr_done),
    .arr_req(arr_req), .arr_op(arr_op), .arr_page(arr_page), .busy(busy),
    .set_lk(set_lk), .clr_lk(clr_lk), .set_sec(set_sec), .clr_sec(clr_sec),
    .region(region), .ev(ev)
  );

  fg_lock_bank #(.REGIONS(REGIONS)) u_lock (
    .clk(clk), .rst_n(rst_n), .set_lk(set_lk), .clr_lk(clr_lk),
    .region(region), .wipe_locks(pin_fire), .set_sec(set_sec),
    .clr_sec(clr_sec), .locks(lock_q), .secure(secure)
  );

  fg_status u_sts (
    .clk(clk), .rst_n(rst_n), .ev(ev), .sts_rd(sts_rd), .ie_done(ie_done),
    .ie_lock(ie_lock), .ie_cmd(ie_cmd), .flags(flags), .irq(irq)
  );

  assign st_done     = flags.done;
  assign st_lock_err = flags.lock_err;
  assign st_cmd_err  = flags.cmd_err;
  assign dbg_gnt     = dbg_req & ~secure;
  assign xprog_gnt   = xprog_req & ~secure;
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
  parameter int         REGIONS = 8,
  parameter logic [7:0] KEY     = 8'hA5,
  parameter int         PW      = 8,
  parameter int         RW      = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_wr,
  input logic [31:0]        cmd_word,
  input logic               busy,
  input logic [REGIONS-1:0] lock_q,
  input logic               secure,
  input logic               dbg_gnt,
  input logic               xprog_gnt,
  input logic               arr_req,
  input logic [1:0]         arr_op,
  input logic               arr_done,
  input logic               st_cmd_err
);
  logic [RW-1:0] c_region;
  logic          c_page_op;
  assign c_region  = cmd_word[8 + PW - 1 -: RW];
  assign c_page_op = (cmd_word[2:0] == 3'd1) || (cmd_word[2:0] == 3'd2);

  // R2: request is a single-cycle pulse and busy covers the cycle after it
  a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req |=> (!arr_req && busy));

  // R3: a page operation into a locked region is never issued
  a_r3_locked_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && cmd_word[31:24] == KEY && c_page_op && lock_q[c_region])
    |=> (!arr_req || arr_op == 2'd2));

  // R6: security rises only from a command write
  a_r6_sec_set_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(secure) |-> $past(cmd_wr));

  // R6: security falls only on an array completion
  a_r6_sec_clear_after_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(secure) |-> $past(arr_done));

  // R7: no grant while secure
  a_r7_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    secure |-> (!dbg_gnt && !xprog_gnt));

  // R10: a write while busy is flagged and not issued
  a_r10_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> (st_cmd_err && !arr_req));
endmodule

bind flash_guard flash_guard_chk #(.REGIONS(REGIONS), .KEY(KEY), .PW(PW), .RW(RW)) u_chk (.*);

// File: tb/flash_guard_test.sv
module flash_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] KEY = 8'hA5;

  logic clk = 0, rst_n = 0;
  logic cmd_wr = 0, sts_rd = 0, ie_done = 0, ie_lock = 0, ie_cmd = 0;
  logic erase_pin = 0, dbg_req = 0, xprog_req = 0, arr_done = 0;
  logic [31:0] cmd_word = '0;
  logic busy, st_done, st_lock_err, st_cmd_err, irq, secure, dbg_gnt, xprog_gnt, arr_req;
  logic [7:0] lock_q, arr_page;
  logic [1:0] arr_op;

  int checks = 0, fails = 0, reqs = 0, stub_cnt = 0;
  logic [1:0] last_op = '0;
  logic [7:0] last_page = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_guard #(.KEY(KEY), .TICK_CYCLES(4), .HOLD_MS(3)) uut (.*);

  // array stub: done pulse a few cycles after each request
  always @(posedge clk) begin
    if (arr_req) begin
      stub_cnt  <= 3;
      reqs      <= reqs + 1;
      last_op   <= arr_op;
      last_page <= arr_page;
      arr_done  <= 1'b0;
    end else begin
      if (stub_cnt != 0) stub_cnt <= stub_cnt - 1;
      arr_done <= (stub_cnt == 1);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [31:0] w);
    cmd_word = w; cmd_wr = 1; @(negedge clk); cmd_wr = 0;
  endtask

  task automatic clr();
    sts_rd = 1; @(negedge clk); sts_rd = 0;
  endtask

  // {tag, word, exp_req, exp_done, exp_lock_err, exp_cmd_err}
  localparam int NV = 11;
  localparam logic [39:0] VEC [NV] = '{
    {4'd2,  32'hA5001001, 4'b1100},  // R2 program page 0x10
    {4'd1,  32'h5A001001, 4'b0001},  // R1 bad key
    {4'd4,  32'hA5002504, 4'b0100},  // R4 lock region 1
    {4'd3,  32'hA5003001, 4'b0010},  // R3 program into locked region
    {4'd3,  32'hA5003F02, 4'b0010},  // R3 erase last page of locked region
    {4'd2,  32'hA5004002, 4'b1100},  // R2 erase page in free region
    {4'd5,  32'hA5000003, 4'b0010},  // R5 full erase refused by lock
    {4'd4,  32'hA5002005, 4'b0100},  // R4 unlock region 1
    {4'd5,  32'hA5000003, 4'b1100},  // R5 full erase allowed
    {4'd10, 32'hA5000007, 4'b0001},  // R10 opcode 7
    {4'd10, 32'hA5000000, 4'b0001}   // R10 opcode 0
  };

  initial begin
    tick(3); rst_n = 1; tick(1);
    chk("R2 reset busy", busy, 0);
    chk("R11 reset flags", {st_done, st_lock_err, st_cmd_err, irq}, 0);
    chk("R4 reset locks", lock_q, 0);
    chk("R6 reset secure", secure, 0);

    for (int i = 0; i < NV; i++) begin
      automatic int r0;
      automatic string t = $sformatf("R%0d vec%0d", VEC[i][39:36], i);
      clr();
      r0 = reqs;
      send(VEC[i][35:4]);
      tick(10);
      chk({t, " req"}, reqs - r0, {31'b0, VEC[i][3]});
      chk({t, " done"}, st_done, VEC[i][2]);
      chk({t, " lock_err"}, st_lock_err, VEC[i][1]);
      chk({t, " cmd_err"}, st_cmd_err, VEC[i][0]);
      if (i == 0) chk("R2 op/page", {last_op, last_page}, {2'd0, 8'h10});
      if (i == 2) chk("R4 lock set", lock_q, 8'h02);
      if (i == 8) chk("R5 full erase op", last_op, 2'd2);
    end
    chk("R4 lock cleared", lock_q, 8'h00);

    // R10: write while busy
    begin
      automatic int r0;
      clr(); r0 = reqs;
      send(32'hA5005001);
      chk("R10 busy high", busy, 1);
      send(32'hA5006001);
      tick(10);
      chk("R10 one request", reqs - r0, 1);
      chk("R10 cmd_err", st_cmd_err, 1);
      chk("R10 first done", st_done, 1);
      chk("R2 busy drop", busy, 0);
    end

    // R11: read clears, irq follows enabled flags
    clr();
    chk("R11 cleared", {st_done, st_lock_err, st_cmd_err}, 0);
    ie_lock = 1;
    send(32'hA5006004); tick(2);
    chk("R4 lock region 3", lock_q, 8'h08);
    chk("R11 irq masked done", irq, 0);
    send(32'hA5006101); tick(3);
    chk("R11 irq on lock_err", irq, 1);
    clr();
    chk("R11 irq cleared", irq, 0);
    ie_lock = 0;

    // R6/R7 security
    dbg_req = 1; xprog_req = 1; tick(1);
    chk("R7 grant open", {dbg_gnt, xprog_gnt}, 2'b11);
    send(32'hA5000006); tick(2);
    chk("R6 secure set", secure, 1);
    chk("R7 grants denied", {dbg_gnt, xprog_gnt}, 2'b00);

    // R8 short pulse ignored
    begin
      automatic int r0 = reqs;
      erase_pin = 1; tick(12); erase_pin = 0; tick(15);
      chk("R8 short pulse no req", reqs - r0, 0);
      chk("R8 short pulse locks kept", lock_q, 8'h08);
      chk("R8 short pulse secure kept", secure, 1);
    end

    // R9 valid erase pin
    begin
      automatic bit seen = 0;
      erase_pin = 1;
      for (int k = 0; k < 40 && !seen; k++) begin
        @(negedge clk);
        if (arr_req) seen = 1;
      end
      chk("R9 wipe requested", seen, 1);
      chk("R9 locks wiped", lock_q, 8'h00);
      chk("R9 secure held during wipe", secure, 1);
      chk("R9 wipe op", arr_op, 2'd2);
      seen = 0;
      for (int k = 0; k < 20 && !seen; k++) begin
        @(negedge clk);
        if (arr_done) seen = 1;
      end
      tick(2);
      chk("R9 secure cleared", secure, 0);
      chk("R7 grant restored", dbg_gnt, 1);
      erase_pin = 0; tick(4);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R1..all actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule